// File: doc/BRIEF.md
# Serial-to-Parallel Deserializer with Bit Slip

This block gathers a serial bit stream, one bit per rising edge of the bit-rate clock, into 4-bit parallel words. A 2-bit source select picks the stream. The choices are the recovered data, the raw line input that bypasses recovery, and a loopback stream taken from the transmit side. One code is left unused; it silences the output. Every completed word is presented together with a one-cycle valid strobe. A parallel clock is also produced, and its edges line up with the word updates.

An asynchronous sync request lets the system move the word boundary. The block synchronizes the request and only accepts it once it has been seen for at least two clocks. Each accepted request swallows exactly one serial bit, so every later word starts one bit position further along the stream. The parallel clock runs at the word rate by default. In double-data-rate mode it runs at half the word rate, and each of its edges then marks a new word.

Top module: `deser_bitslip`

## Requirements
- R1: Bits are packed LSB first. The first bit accepted for a word lands in `word_o[0]` and the fourth lands in `word_o[3]`.
- R2: `word_vld_o` is high for exactly one clock after each fourth accepted bit, and `word_o` updates in that same clock. Two strobes are never adjacent.
- R3: `src_sel_i[0]` and `src_sel_i[1]` select the source. The value 2'b11 picks `rec_bit_i`, 2'b01 picks `loop_bit_i` and 2'b10 picks `raw_bit_i`.
- R4: With `src_sel_i` = 2'b00, no bit is accepted. `word_o` reads 0 and `word_vld_o` stays low from the next clock on, and the bit position is kept.
- R5: With the raw source selected, the value taken for a bit is the one `raw_bit_i` holds at the falling clock edge before the rising edge that uses it.
- R6: Suppose `sync_req_i` is first high before rising edge N and stays high for at least two rising edges. Then the bit presented for edge N+3 is discarded. The word in progress completes one clock later, and the bit after the discarded one takes its slot.
- R7: A sync request held high for many clocks discards exactly one bit.
- R8: A sync request that is high for only one rising edge discards no bit.
- R9: In normal mode, `pclk_o` is high for the two clocks that start with each word update and low for the next two. This gives a divide-by-4 of the bit clock while bits keep flowing.
- R10: In double-data-rate mode (`ddr_mode_i` = 1), `pclk_o` toggles in each clock where a new word appears. This gives a divide-by-8 of the bit clock.
- R11: After synchronous reset, `word_o` is 0, `word_vld_o` is 0, `pclk_o` is 0, and the next accepted bit goes to position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_i | input | 1 | Synchronous reset, active high |
| src_sel_i | input | 2 | Serial source select |
| rec_bit_i | input | 1 | Recovered serial data |
| raw_bit_i | input | 1 | Raw line data, captured on the falling edge |
| loop_bit_i | input | 1 | Loopback serial data from the transmit side |
| sync_req_i | input | 1 | Asynchronous word-boundary slip request |
| ddr_mode_i | input | 1 | Selects the half-word-rate parallel clock |
| word_o | output | 4 | Assembled parallel word |
| word_vld_o | output | 1 | One-clock strobe for a new word |
| pclk_o | output | 1 | Parallel output clock |

## Verification
A table of words is sent through each source while the unselected inputs carry the inverted bits. A correct word therefore shows that the right source was chosen and that the bit order is right. The raw path gets a pattern that flips the input between the falling and rising edges, so capture on the wrong edge returns the complement. Sync pulses of random length at random offsets are checked against a reference that drops one bit per accepted pulse. One-clock and very long pulses separate the qualifier from a plain edge detector. Runs in both clock modes compare `pclk_o` every clock against the expected divide-by-4 and divide-by-8 waveforms.

// File: rtl/deser_pkg.sv
package deser_pkg;

    localparam int WORD_W      = 4;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SRC_NONE = 2'b00,
        SRC_LOOP = 2'b01,
        SRC_RAW  = 2'b10,
        SRC_REC  = 2'b11
    } src_e;

    function automatic logic src_active(input src_e s);
        return s != SRC_NONE;
    endfunction

endpackage

// File: rtl/deser_src_mux.sv
module deser_src_mux
    import deser_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [1:0] sel_i,
    input  logic       rec_bit_i,
    input  logic       raw_bit_i,
    input  logic       loop_bit_i,
    output logic       bit_o,
    output logic       active_o
);

    logic raw_fall_q;
    src_e sel;

    assign sel = src_e'(sel_i);

    // raw line is captured half a cycle early, on the falling edge
    always_ff @(negedge clk_i) begin
        if (rst_i) raw_fall_q <= 1'b0;
        else       raw_fall_q <= raw_bit_i;
    end

    always_comb begin
        unique case (sel)
            SRC_REC:  bit_o = rec_bit_i;
            SRC_RAW:  bit_o = raw_fall_q;
            SRC_LOOP: bit_o = loop_bit_i;
            default:  bit_o = 1'b0;
        endcase
        active_o = src_active(sel);
    end

endmodule

// File: rtl/deser_slip_sync.sv
module deser_slip_sync #(
    parameter int STAGES = deser_pkg::SYNC_STAGES
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic req_i,
    output logic slip_o
);

    logic [STAGES-1:0] meta_q;
    logic              prev_q;
    logic              held;
    logic              held_d_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            meta_q   <= '0;
            prev_q   <= 1'b0;
            held_d_q <= 1'b0;
        end else begin
            meta_q   <= {meta_q[STAGES-2:0], req_i};
            prev_q   <= meta_q[STAGES-1];
            held_d_q <= held;
        end
    end

    // request must be seen on two consecutive synchronized samples
    assign held   = meta_q[STAGES-1] & prev_q;
    assign slip_o = held & ~held_d_q;

    // R7
    single_slip_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        slip_o |=> !slip_o);

endmodule

// File: rtl/deser_word_asm.sv
module deser_word_asm #(
    parameter int WORD_W = deser_pkg::WORD_W,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              bit_i,
    input  logic              active_i,
    input  logic              slip_i,
    output logic [WORD_W-1:0] word_o,
    output logic              vld_o,
    output logic [CNT_W-1:0]  cnt_next_o,
    output logic              done_o
);

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_nx;
    logic              take;

    assign take   = active_i & ~slip_i;
    assign done_o = take & (cnt_q == CNT_W'(WORD_W - 1));

    always_comb begin
        acc_nx = acc_q;
        if (take) acc_nx[cnt_q] = bit_i;
        if (done_o)    cnt_next_o = '0;
        else if (take) cnt_next_o = cnt_q + CNT_W'(1);
        else           cnt_next_o = cnt_q;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            word_o <= '0;
            vld_o  <= 1'b0;
        end else begin
            cnt_q <= cnt_next_o;
            acc_q <= acc_nx;
            vld_o <= done_o;
            if (!active_i)   word_o <= '0;
            else if (done_o) word_o <= acc_nx;
        end
    end

    // R2
    vld_spacing_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        vld_o |=> !vld_o);

    // R4
    unused_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !active_i |=> (word_o == '0) && !vld_o);

    // R6
    slip_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        slip_i |=> $stable(cnt_q));

endmodule

// File: rtl/deser_pclk_gen.sv
module deser_pclk_gen #(
    parameter int WORD_W = deser_pkg::WORD_W,
    localparam int CNT_W = $clog2(WORD_W)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             ddr_i,
    input  logic [CNT_W-1:0] cnt_next_i,
    input  logic             done_i,
    output logic             pclk_o
);

    always_ff @(posedge clk_i) begin
        if (rst_i)      pclk_o <= 1'b0;
        else if (ddr_i) pclk_o <= pclk_o ^ done_i;
        else            pclk_o <= (cnt_next_i < CNT_W'(WORD_W / 2));
    end

    // R9
    pclk_align_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (!ddr_i && done_i) |=> pclk_o);

    // R10
    ddr_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (ddr_i && done_i) |=> (pclk_o != $past(pclk_o)));

endmodule

// File: rtl/deser_bitslip.sv
module deser_bitslip #(
    parameter int WORD_W      = deser_pkg::WORD_W,
    parameter int SYNC_STAGES = deser_pkg::SYNC_STAGES,
    localparam int CNT_W      = $clog2(WORD_W)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [1:0]        src_sel_i,
    input  logic              rec_bit_i,
    input  logic              raw_bit_i,
    input  logic              loop_bit_i,
    input  logic              sync_req_i,
    input  logic              ddr_mode_i,
    output logic [WORD_W-1:0] word_o,
    output logic              word_vld_o,
    output logic              pclk_o
);

    logic             ser_bit;
    logic             ser_active;
    logic             slip;
    logic [CNT_W-1:0] cnt_next;
    logic             word_done;

    deser_src_mux u_mux (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .sel_i      (src_sel_i),
        .rec_bit_i  (rec_bit_i),
        .raw_bit_i  (raw_bit_i),
        .loop_bit_i (loop_bit_i),
        .bit_o      (ser_bit),
        .active_o   (ser_active)
    );

    deser_slip_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .req_i  (sync_req_i),
        .slip_o (slip)
    );

    deser_word_asm #(.WORD_W(WORD_W)) u_asm (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .bit_i      (ser_bit),
        .active_i   (ser_active),
        .slip_i     (slip),
        .word_o     (word_o),
        .vld_o      (word_vld_o),
        .cnt_next_o (cnt_next),
        .done_o     (word_done)
    );

    deser_pclk_gen #(.WORD_W(WORD_W)) u_pclk (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .ddr_i      (ddr_mode_i),
        .cnt_next_i (cnt_next),
        .done_i     (word_done),
        .pclk_o     (pclk_o)
    );

endmodule

// File: tb/tb_deser_bitslip.sv
module tb_deser_bitslip;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_sel = 2'b11;
    logic       rec_bit = 1'b0, raw_bit = 1'b0, loop_bit = 1'b0;
    logic       sync_req = 1'b0;
    logic       ddr_mode = 1'b0;
    logic [3:0] word;
    logic       word_vld;
    logic       pclk;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int drop_at = -1;
    int sync_left = 0;
    int m_cnt = 0;
    logic [3:0] m_acc = '0;
    logic m_pclk = 1'b0;
    logic done_flag = 1'b0;

    // vector: {sel[1:0], data[3:0]}; expected word equals data
    localparam logic [5:0] VEC [8] = '{
        {2'b11, 4'b0001}, {2'b11, 4'b1000}, {2'b01, 4'b0110}, {2'b01, 4'b1011},
        {2'b10, 4'b0100}, {2'b10, 4'b1101}, {2'b11, 4'b1010}, {2'b01, 4'b0011}
    };

    deser_bitslip dut (
        .clk_i(clk), .rst_i(rst), .src_sel_i(src_sel),
        .rec_bit_i(rec_bit), .raw_bit_i(raw_bit), .loop_bit_i(loop_bit),
        .sync_req_i(sync_req), .ddr_mode_i(ddr_mode),
        .word_o(word), .word_vld_o(word_vld), .pclk_o(pclk)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // drive one bit (called at posedge+2), advance one edge, check outputs
    task automatic push(input logic b, input logic [1:0] sel, input logic glitch, input string tag);
        logic active, drop, emit;
        src_sel  = sel;
        rec_bit  = (sel == 2'b11) ? b : ~b;
        loop_bit = (sel == 2'b01) ? b : ~b;
        raw_bit  = (sel == 2'b10) ? b : ~b;
        if (sel == 2'b00) begin rec_bit = b; loop_bit = b; raw_bit = b; end
        sync_req = (sync_left > 0);
        if (sync_left > 0) sync_left--;
        if (glitch) begin #4; raw_bit = ~b; end
        @(posedge clk); #2;
        cyc++;
        active = (sel != 2'b00);
        drop   = (cyc == drop_at);
        emit   = 1'b0;
        if (active && !drop) begin
            m_acc[m_cnt] = b;
            if (m_cnt == 3) begin emit = 1'b1; m_cnt = 0; end
            else m_cnt++;
        end
        if (ddr_mode) m_pclk = m_pclk ^ emit;
        else          m_pclk = (m_cnt < 2);
        chk(word_vld == emit, "R2", int'(word_vld), int'(emit));
        if (emit) chk(word == m_acc, tag, int'(word), int'(m_acc));
        if (!active) chk(word == 4'd0 && !word_vld, "R4", int'(word), 0);
        chk(pclk == m_pclk, ddr_mode ? "R10" : "R9", int'(pclk), int'(m_pclk));
    endtask

    task automatic start_sync(input int hold);
        sync_left = hold;
        if (hold >= 2) drop_at = cyc + 4;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R11 reset state
        chk(word == 4'd0, "R11", int'(word), 0);
        chk(!word_vld, "R11", int'(word_vld), 0);
        chk(!pclk, "R11", int'(pclk), 0);
        rst = 1'b0;

        // table walk: sources (R3) and bit order (R1)
        for (int v = 0; v < 8; v++) begin
            for (int i = 0; i < 4; i++)
                push(VEC[v][i], VEC[v][5:4], 1'b0, "R3");
            chk(word == VEC[v][3:0], "R1", int'(word), int'(VEC[v][3:0]));
        end

        // R5 raw captured on falling edge: value flips before the rising edge
        for (int i = 0; i < 4; i++) push(i[0] ? 1'b1 : 1'b0, 2'b10, 1'b1, "R5");
        for (int i = 0; i < 4; i++) push(i == 2, 2'b10, 1'b1, "R5");

        // R4 unused source
        for (int i = 0; i < 6; i++) push(1'b1, 2'b00, 1'b0, "R4");
        for (int i = 0; i < 8; i++) push(i[1], 2'b11, 1'b0, "R4");

        // R6 slips with random hold lengths at random offsets
        for (int s = 0; s < 6; s++) begin
            int gap, hold;
            gap  = $urandom_range(0, 7);
            hold = $urandom_range(2, 5);
            for (int i = 0; i < gap; i++) push($urandom_range(0, 1) == 1, 2'b11, 1'b0, "R6");
            start_sync(hold);
            for (int i = 0; i < hold + 14; i++) push($urandom_range(0, 1) == 1, 2'b11, 1'b0, "R6");
        end

        // R8 one-clock sync pulse is ignored
        start_sync(1);
        for (int i = 0; i < 12; i++) push($urandom_range(0, 1) == 1, 2'b11, 1'b0, "R8");

        // R7 long hold slips once
        start_sync(12);
        for (int i = 0; i < 24; i++) push($urandom_range(0, 1) == 1, 2'b11, 1'b0, "R7");

        // R10 double-data-rate clock
        ddr_mode = 1'b1;
        for (int i = 0; i < 24; i++) push(i[0] ^ i[2], 2'b01, 1'b0, "R10");
        start_sync(3);
        for (int i = 0; i < 16; i++) push(i[1], 2'b01, 1'b0, "R10");
        ddr_mode = 1'b0;
        for (int i = 0; i < 12; i++) push(i[0], 2'b11, 1'b0, "R9");

        finish_run();
    end

endmodule